// File: doc/BRIEF.md
# Two-Wire Bus Slave with Pointer-Addressed Register Access

This block is the bus-facing half of a small sensor register bank. It runs on a fast system clock that oversamples the two-wire lines. The SCL and SDA inputs arrive already filtered and synchronised. The block drives SDA only through an open-drain enable. A pointer, loaded by the first byte of every write, picks one of four 16-bit registers. The pointer keeps its value across transactions, so repeated reads need no new pointer byte. Index 0 holds the measured value and is read-only. Index 1 is configuration, index 2 is the lower limit and index 3 is the upper limit.

Beyond plain register access, the block answers the general-call address and the alert response address. On general call it either asks the register bank to reset or re-samples its address-select input. On the alert response it sends back its own address and an over/under bit, and it withdraws if another device wins the bus. A stuck-bus timer releases the line when SCL or SDA stays low too long inside a transaction.

The register bank is on the other side of a strobe interface that has no back-pressure, because the bus cannot be stalled. A write strobe (`wr_valid_o`) is a single-cycle pulse that the bank must accept in that cycle. A read is answered combinationally: `rd_data_i` must reflect `rd_sel_o` in the cycle that `rd_req_o` is high. The general-call reset and alert-clear outputs are single-cycle pulses.

Top module: `twi_regif_slave`

## Requirements
- R1: The 7-bit own address is 1001000 when `a0_sel_i` is 00, 1001001 when it is 01 and 1001010 when it is 10 (11 is treated as 00). It is sampled at every START. A matching address byte is acknowledged by driving SDA low in the ninth clock; a non-matching one is left unacknowledged.
- R2: In a write, the first byte after the address loads the pointer from its two low bits (00 measured, 01 configuration, 10 lower limit, 11 upper limit). The pointer is 00 after reset and is visible on `rd_sel_o`. A write carrying only the pointer byte is legal, and later reads use the pointer until it is rewritten.
- R3: A read returns the selected register high byte first, then low byte, each MSB first. The four least significant bits of the low byte always read 0.
- R4: When the master does not acknowledge a read byte, the block stops driving SDA until the next START. After a STOP, SDA is released.
- R5: In a write, every pair of data bytes after the pointer produces one `wr_valid_o` pulse. It carries `wr_sel_o` equal to the pointer and `wr_data_o` equal to the first byte followed by the second. Pointer 00 data bytes are acknowledged but produce no pulse.
- R6: Address byte 0x00 (general call, write) is acknowledged. A following 0x06 is acknowledged, pulses `regs_reset_o` and returns the pointer to 00. A following 0x04 is acknowledged and only re-samples `a0_sel_i`, leaving the pointer unchanged and giving no reset pulse.
- R7: Address byte 0x19 (alert response, read) is acknowledged only while `alert_active_i` is high. The block then sends its own address with `alert_over_i` as the LSB. It pulses `alert_clear_o` once all eight bits have gone out unchallenged.
- R8: If, during a byte the block is sending, SDA reads low on an SCL rise while the block has it released, the block stops driving until the next START and gives no `alert_clear_o` pulse.
- R9: An address byte of the form 00001xxx (high-speed master code) is never acknowledged.
- R10: Between START and STOP, if SCL or SDA stays low for `TIMEOUT_CYC` cycles with no SCL edge, SDA is released and the bus is ignored until the next START.
- R11: SDA drive only begins while SCL is low, and the write, read, reset and clear pulses never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered, synchronised SCL level |
| sda_i | input | 1 | Filtered, synchronised SDA level |
| a0_sel_i | input | 2 | Address select: 00 ground, 01 supply, 10 data line |
| sda_oe_o | output | 1 | Pull SDA low when high |
| rd_req_o | output | 1 | Read-request pulse at read-address acknowledge |
| rd_sel_o | output | 2 | Current pointer, selects read data |
| rd_data_i | input | 16 | Register value for `rd_sel_o`, combinational |
| wr_valid_o | output | 1 | Write strobe pulse |
| wr_sel_o | output | 2 | Register index of the write |
| wr_data_o | output | 16 | Write data, high byte first received |
| alert_active_i | input | 1 | Alert condition currently asserted |
| alert_over_i | input | 1 | 1 = above upper limit, 0 = below lower limit |
| alert_clear_o | output | 1 | Pulse: alert response won, clear the alert |
| regs_reset_o | output | 1 | Pulse: return registers to power-up values |

## Verification
A corrupt pointer shows up at once on `rd_sel_o` and, on the next read, as bytes from the wrong register. A bit counter that is out of step shifts the acknowledge into a data slot, so the master sees a missing ACK or shifted data within one byte. A mode that sticks after a NACK, a lost arbitration or a timeout shows as SDA pulled low during bits the block should leave alone, within the next nine SCL clocks. Strobes are compared one by one against expected writes, resets and alert clears, so a spurious or missing pulse is caught at the cycle it happens.

// File: rtl/twi_regif_pkg.sv
package twi_regif_pkg;
  typedef enum logic [2:0] {
    MD_IDLE, MD_ADDR, MD_WPTR, MD_WMSB, MD_WLSB, MD_GC, MD_READ, MD_ARA
  } mode_t;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] ARA_BYTE     = 8'h19;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [7:0] GC_LATCH_CMD = 8'h04;
  localparam logic [4:0] HS_CODE_TOP  = 5'b00001;
endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/twi_stuck_timer.sv
module twi_stuck_timer #(
  parameter int LIMIT = 3_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic lines_high_i,
  input  logic edge_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt <= '0;
    else if (!busy_i || edge_i || lines_high_i) cnt <= '0;
    else if (cnt != LIM)                        cnt <= cnt + 1'b1;
  end

  assign expire_o = busy_i && (cnt == LIM);
endmodule

// File: rtl/twi_addr_latch.sv
module twi_addr_latch #(
  parameter logic [6:0] BASE_ADDR = 7'b1001000,
  parameter int         SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [6:0]       addr_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (load_i) sel_q <= sel_i;
  end

  always_comb begin
    unique case (sel_q)
      2'd1:    addr_o = BASE_ADDR + 7'd1;
      2'd2:    addr_o = BASE_ADDR + 7'd2;
      default: addr_o = BASE_ADDR;
    endcase
  end
endmodule

// File: rtl/twi_regif_slave.sv
module twi_regif_slave
  import twi_regif_pkg::*;
#(
  parameter int         DATA_W      = 16,
  parameter int         SEL_W       = 2,
  parameter int         PAD_BITS    = 4,
  parameter int         TIMEOUT_CYC = 3_750_000,
  parameter logic [6:0] BASE_ADDR   = 7'b1001000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        a0_sel_i,
  output logic              sda_oe_o,
  output logic              rd_req_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              alert_active_i,
  input  logic              alert_over_i,
  output logic              alert_clear_o,
  output logic              regs_reset_o
);
  localparam logic [DATA_W-1:0] RD_MASK = {{(DATA_W-PAD_BITS){1'b1}}, {PAD_BITS{1'b0}}};

  logic start_p, stop_p, rise_p, fall_p, tmo_p;
  logic [6:0] own_addr;
  logic relatch;

  mode_t mode, nxt_mode;
  logic [3:0]        bitn;
  logic [7:0]        shreg;
  logic [7:0]        msb_hold;
  logic [DATA_W-1:0] txword;
  logic              byte_idx;
  logic              busy;
  logic [SEL_W-1:0]  ptr;

  twi_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_p), .stop_o(stop_p), .rise_o(rise_p), .fall_o(fall_p)
  );

  twi_stuck_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .lines_high_i(scl_i & sda_i),
    .edge_i(rise_p | fall_p), .expire_o(tmo_p)
  );

  twi_addr_latch #(.BASE_ADDR(BASE_ADDR), .SEL_W(2)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(start_p | relatch), .sel_i(a0_sel_i),
    .addr_o(own_addr)
  );

  wire       is_tx   = (mode == MD_READ) || (mode == MD_ARA);
  wire [2:0] bit_sel = 3'd7 - bitn[2:0];
  wire [7:0] rd_byte = byte_idx ? txword[7:0] : txword[DATA_W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MD_IDLE; nxt_mode <= MD_IDLE; bitn <= '0; shreg <= '0;
      msb_hold <= '0; txword <= '0; byte_idx <= 1'b0; busy <= 1'b0;
      ptr <= '0; sda_oe_o <= 1'b0; rd_req_o <= 1'b0; wr_valid_o <= 1'b0;
      wr_sel_o <= '0; wr_data_o <= '0; alert_clear_o <= 1'b0;
      regs_reset_o <= 1'b0; relatch <= 1'b0;
    end else begin
      rd_req_o <= 1'b0; wr_valid_o <= 1'b0; alert_clear_o <= 1'b0;
      regs_reset_o <= 1'b0; relatch <= 1'b0;
      if (tmo_p) begin
        mode <= MD_IDLE; nxt_mode <= MD_IDLE; sda_oe_o <= 1'b0; busy <= 1'b0;
      end else if (start_p) begin
        mode <= MD_ADDR; nxt_mode <= MD_ADDR; bitn <= '0; sda_oe_o <= 1'b0; busy <= 1'b1;
      end else if (stop_p) begin
        mode <= MD_IDLE; nxt_mode <= MD_IDLE; sda_oe_o <= 1'b0; busy <= 1'b0;
      end else if (mode != MD_IDLE) begin
        if (rise_p) begin
          bitn <= (bitn == 4'd8) ? 4'd0 : bitn + 4'd1;
          if (bitn != 4'd8) begin
            if (!is_tx) shreg <= {shreg[6:0], sda_i};
            else if (!sda_oe_o && !sda_i) begin
              mode <= MD_IDLE; nxt_mode <= MD_IDLE;       // lost the bus
            end
          end else if (is_tx && sda_i) begin
            mode <= MD_IDLE; nxt_mode <= MD_IDLE;         // master NACK
          end
        end else if (fall_p) begin
          if (bitn == 4'd8) begin
            if (is_tx) begin
              sda_oe_o <= 1'b0;
              if (mode == MD_ARA) begin
                alert_clear_o <= 1'b1;
                nxt_mode      <= MD_IDLE;
              end
            end else begin
              sda_oe_o <= 1'b1;
              unique case (mode)
                MD_ADDR: begin
                  if (shreg[7:3] == HS_CODE_TOP) begin
                    sda_oe_o <= 1'b0; nxt_mode <= MD_IDLE;
                  end else if (shreg[7:1] == own_addr) begin
                    if (shreg[0]) begin
                      nxt_mode <= MD_READ; txword <= rd_data_i & RD_MASK;
                      rd_req_o <= 1'b1; byte_idx <= 1'b0;
                    end else nxt_mode <= MD_WPTR;
                  end else if (shreg == GC_ADDR_BYTE) begin
                    nxt_mode <= MD_GC;
                  end else if (shreg == ARA_BYTE && alert_active_i) begin
                    nxt_mode <= MD_ARA; shreg <= {own_addr, alert_over_i};
                  end else begin
                    sda_oe_o <= 1'b0; nxt_mode <= MD_IDLE;
                  end
                end
                MD_WPTR: begin ptr <= shreg[SEL_W-1:0]; nxt_mode <= MD_WMSB; end
                MD_WMSB: begin msb_hold <= shreg; nxt_mode <= MD_WLSB; end
                MD_WLSB: begin
                  nxt_mode <= MD_WMSB;
                  if (ptr != '0) begin
                    wr_valid_o <= 1'b1; wr_sel_o <= ptr; wr_data_o <= {msb_hold, shreg};
                  end
                end
                MD_GC: begin
                  nxt_mode <= MD_IDLE;
                  if (shreg == GC_RESET_CMD) begin
                    regs_reset_o <= 1'b1; ptr <= '0;
                  end else if (shreg == GC_LATCH_CMD) relatch <= 1'b1;
                end
                default: begin sda_oe_o <= 1'b0; nxt_mode <= MD_IDLE; end
              endcase
            end
          end else if (bitn == 4'd0) begin
            mode <= nxt_mode;
            if (nxt_mode == MD_READ) begin
              shreg <= rd_byte; sda_oe_o <= ~rd_byte[7]; byte_idx <= ~byte_idx;
            end else if (nxt_mode == MD_ARA) begin
              sda_oe_o <= ~shreg[7];
            end else sda_oe_o <= 1'b0;
          end else if (is_tx) begin
            sda_oe_o <= ~shreg[bit_sel];
          end
        end
      end
    end
  end

  assign rd_sel_o = ptr;
endmodule

// File: rtl/twi_regif_chk.sv
module twi_regif_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             sda_oe_o,
  input logic             rd_req_o,
  input logic             wr_valid_o,
  input logic [SEL_W-1:0] wr_sel_o,
  input logic             alert_clear_o,
  input logic             regs_reset_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= scl_i; sda_q <= sda_i; end
  end

  AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);  // R11
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_o, wr_valid_o, alert_clear_o, regs_reset_o}));  // R11
  AST_NO_MEASURED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_sel_o != '0));  // R5
  AST_WRITE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);  // R5
  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q && !sda_q && sda_i) |=> !sda_oe_o);  // R4
  AST_CLEAR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clear_o |=> !alert_clear_o);  // R7
endmodule

bind twi_regif_slave twi_regif_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
  .rd_req_o(rd_req_o), .wr_valid_o(wr_valid_o), .wr_sel_o(wr_sel_o),
  .alert_clear_o(alert_clear_o), .regs_reset_o(regs_reset_o)
);

// File: tb/twi_regif_slave_tb.sv
module twi_regif_slave_tb;
  localparam int Q   = 5;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  logic [1:0] a0_sel = 2'd0;
  logic alert_active = 1'b0, alert_over = 1'b0;
  logic [15:0] regmem [4];
  logic rd_req, wr_valid, alert_clear, regs_reset;
  logic [1:0] rd_sel, wr_sel;
  logic [15:0] rd_data, wr_data;
  assign rd_data = regmem[rd_sel];

  twi_regif_slave #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .a0_sel_i(a0_sel),
    .sda_oe_o(sda_oe), .rd_req_o(rd_req), .rd_sel_o(rd_sel), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .alert_active_i(alert_active), .alert_over_i(alert_over),
    .alert_clear_o(alert_clear), .regs_reset_o(regs_reset)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: kind 1 write, 2 register reset, 3 alert clear
  typedef struct packed { logic [1:0] kind; logic [1:0] sel; logic [15:0] data; } ev_t;
  ev_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && (wr_valid || regs_reset || alert_clear)) begin
      ev_t got, e;
      got.kind = wr_valid ? 2'd1 : (regs_reset ? 2'd2 : 2'd3);
      got.sel  = wr_valid ? wr_sel : 2'd0;
      got.data = wr_valid ? wr_data : 16'h0;
      if (exp_q.size() == 0) check(1'b0, "R5/R6/R7 unexpected strobe", 32'(got), 32'h0);
      else begin
        e = exp_q.pop_front();
        check(got == e, (e.kind == 2'd1) ? "R5 write strobe" : (e.kind == 2'd2) ? "R6 reset pulse" : "R7 alert clear",
              32'(got), 32'(e));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic recv_bit(input logic drv, output logic b);
    sda_m = drv; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(1'b1, b);
    ack = ~b;
  endtask
  task automatic recv_byte(input logic [7:0] other, input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(other[i], v[i]);
    send_bit(~mack);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    regmem[0] = 16'h1915; regmem[1] = 16'h60A3; regmem[2] = 16'h8000; regmem[3] = 16'h7FFF;
    tick(5);
    check(sda_oe == 1'b0, "R4 reset releases SDA", sda_oe, 0);
    check(rd_sel == 2'd0, "R2 pointer reset 00", rd_sel, 0);
    rst_n = 1'b1; tick(5);

    // default pointer read
    bus_start; send_byte(8'h91, ack);
    check(ack, "R1 own address 1001000 acked", ack, 1);
    recv_byte(8'hFF, 1'b1, b); check(b == 8'h19, "R3 high byte first", b, 8'h19);
    recv_byte(8'hFF, 1'b0, b); check(b == 8'h10, "R3 low nibble reads 0", b, 8'h10);
    bus_stop;
    check(sda_oe == 1'b0, "R4 released after stop", sda_oe, 0);

    // foreign address
    bus_start; send_byte(8'h92, ack); check(!ack, "R1 other address not acked", ack, 0); bus_stop;

    // pointer-only write, then read persists
    a0_sel = 2'd1;
    bus_start; send_byte(8'h92, ack); check(ack, "R1 select 01 gives 1001001", ack, 1);
    send_byte(8'h03, ack); bus_stop;
    check(rd_sel == 2'd3, "R2 pointer-only write", rd_sel, 3);
    bus_start; send_byte(8'h93, ack);
    recv_byte(8'hFF, 1'b1, b); check(b == 8'h7F, "R2 read uses stored pointer", b, 8'h7F);
    recv_byte(8'hFF, 1'b0, b); check(b == 8'hF0, "R3 low byte masked", b, 8'hF0);
    bus_stop;

    // register write
    a0_sel = 2'd2;
    exp_q.push_back('{kind: 2'd1, sel: 2'd2, data: 16'hE705});
    bus_start; send_byte(8'h94, ack); check(ack, "R1 select 10 gives 1001010", ack, 1);
    send_byte(8'h02, ack); send_byte(8'hE7, ack); send_byte(8'h05, ack);
    check(ack, "R5 data byte acked", ack, 1); bus_stop;
    check(rd_sel == 2'd2, "R2 pointer after write", rd_sel, 2);

    // write to measured register: acked, no strobe
    bus_start; send_byte(8'h94, ack); send_byte(8'h00, ack); send_byte(8'h12, ack);
    send_byte(8'h34, ack); check(ack, "R5 measured write acked", ack, 1); bus_stop;

    // master NACK ends read
    bus_start; send_byte(8'h95, ack);
    recv_byte(8'hFF, 1'b0, b); check(b == 8'h19, "R3 read after pointer 00", b, 8'h19);
    recv_byte(8'hFF, 1'b0, b); check(b == 8'hFF, "R4 silent after NACK", b, 8'hFF);
    bus_stop;

    // general call reset
    bus_start; send_byte(8'h94, ack); send_byte(8'h03, ack); bus_stop;
    exp_q.push_back('{kind: 2'd2, sel: 2'd0, data: 16'h0});
    bus_start; send_byte(8'h00, ack); check(ack, "R6 general call acked", ack, 1);
    send_byte(8'h06, ack); check(ack, "R6 reset command acked", ack, 1); bus_stop;
    check(rd_sel == 2'd0, "R6 pointer back to 00", rd_sel, 0);

    // general call relatch: no reset
    bus_start; send_byte(8'h94, ack); send_byte(8'h01, ack); bus_stop;
    bus_start; send_byte(8'h00, ack); send_byte(8'h04, ack);
    check(ack, "R6 relatch command acked", ack, 1); bus_stop;
    check(rd_sel == 2'd1, "R6 relatch keeps pointer", rd_sel, 1);

    // master code
    bus_start; send_byte(8'h09, ack); check(!ack, "R9 master code not acked", ack, 0); bus_stop;

    // alert response
    a0_sel = 2'd0;
    bus_start; send_byte(8'h19, ack); check(!ack, "R7 no alert, no ack", ack, 0); bus_stop;
    alert_active = 1'b1; alert_over = 1'b1;
    exp_q.push_back('{kind: 2'd3, sel: 2'd0, data: 16'h0});
    bus_start; send_byte(8'h19, ack); check(ack, "R7 alert response acked", ack, 1);
    recv_byte(8'hFF, 1'b0, b); check(b == 8'h91, "R7 address with over bit", b, 8'h91); bus_stop;
    a0_sel = 2'd1; alert_over = 1'b0;
    exp_q.push_back('{kind: 2'd3, sel: 2'd0, data: 16'h0});
    bus_start; send_byte(8'h19, ack);
    recv_byte(8'hFF, 1'b0, b); check(b == 8'h92, "R7 address with under bit", b, 8'h92); bus_stop;

    // arbitration loss
    a0_sel = 2'd0; alert_over = 1'b1;
    bus_start; send_byte(8'h19, ack);
    recv_byte(8'h90, 1'b0, b); check(b == 8'h90, "R8 competitor wins line", b, 8'h90);
    check(sda_oe == 1'b0, "R8 withdrawn after loss", sda_oe, 0);
    bus_stop;
    alert_active = 1'b0;

    // stuck bus timeout
    bus_start;
    for (int i = 7; i >= 0; i--) send_bit(8'h90 >> i);
    check(sda_oe == 1'b1, "R1 ack driven before stall", sda_oe, 1);
    tick(TMO + 20);
    check(sda_oe == 1'b0, "R10 timeout releases SDA", sda_oe, 0);
    send_byte(8'h01, ack); check(!ack, "R10 bus ignored after timeout", ack, 0);
    bus_stop;

    tick(10);
    check(exp_q.size() == 0, "R5 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule